// File: doc/BRIEF.md
# Programmable Even-Ratio Clock Divider Bank

This block takes one fast clock and produces several slower output clocks, one per channel. Each channel has its own divide ratio and its own polarity-invert control. The ratio must be an even number from 2 up to 64. The duty cycle of each output is not programmable. It follows from the ratio alone. Ratio 2 and any multiple of 4 give an exactly even split. Every other legal ratio has a high phase one input cycle shorter than half the period.

The dividers normally advance on every cycle of the fast clock. In bypass mode they advance once for each rising edge of a slower reference input, which is first passed through a two-stage synchronizer. Ratios, invert bits and the bypass select are captured while reset is held, and are frozen once reset is released. Every channel is preloaded during reset. On the first advance after release, every legal channel starts its high phase together, so outputs with different ratios share a first rising edge and no partial pulse is produced.

There is no streaming data path here. All pins are plain control, clock-like or status signals, with no valid/ready handshake. An illegal ratio does not stop the rest of the bank. That channel's output is parked low and its error flag is raised.

Top module: `clkdiv_bank`

## Requirements
- R1: A ratio is legal when it is even and lies in 2..64. Channel i reads its ratio as an unsigned number from bits [7i+6:7i] of `ratio_i`. For a legal ratio, `err_o[i]` is low.
- R2: For ratio V equal to 2 or to a multiple of 4, a non-inverted channel repeats with a period of V advances and stays high for V/2 of them.
- R3: For ratio V of the form 4k+2 with V at least 6, a non-inverted channel repeats every V advances and stays high for V/2-1 of them.
- R4: When a channel's invert bit is 1, its output is the exact complement of the non-inverted waveform, at every cycle.
- R5: For an illegal ratio (odd, below 2 or above 64), `err_o[i]` is 1 and `clk_o[i]` stays 0 in either polarity.
- R6: With bypass selected (1), the dividers advance once per rising edge of `ref_i`. The output therefore has a period of V reference periods and a high time of H reference periods. With no reference edges, the outputs do not move.
- R7: Ratios, invert bits and bypass are sampled only while `rst_ni` is 0. Changes made after release have no effect on any output.
- R8: While in reset, outputs sit at their idle level: legal non-inverted channels are 0, legal inverted channels are 1, and illegal channels are 0. After release, every legal channel begins its first full-length high phase on the same first advance. In direct mode that advance is the first clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast source clock |
| rst_ni | input | 1 | Synchronous active-low reset; settings are captured while low |
| bypass_i | input | 1 | 1 = advance on reference rising edges, 0 = advance on every clock |
| ref_i | input | 1 | Pre-divided reference input, synchronized internally |
| ratio_i | input | NUM_CH*7 | Packed per-channel divide ratios, 7 bits each |
| invert_i | input | NUM_CH | Per-channel output polarity invert |
| clk_o | output | NUM_CH | Divided output clocks |
| err_o | output | NUM_CH | Per-channel illegal-ratio flag |

## Verification
The hardest condition to set up from the ports is bypass mode with a deliberately late reference. Here the bank leaves reset but has nothing to advance on. The outputs must then stay idle, and once edges arrive every channel must still rise together despite the synchronizer latency. The bench releases reset with the reference held low for ten cycles, checks that nothing moves, and then drives a reference with a period of four cycles. It measures each channel's first rise, its period and its high time in clock cycles against V·4 and H·4. In the direct-mode sweeps, the bench scrambles every setting at the moment of release, so any leakage of post-reset inputs shows up as a waveform mismatch.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int DIV_MAX = 64;
  localparam int DIV_W   = $clog2(DIV_MAX + 1);
  localparam int CNT_W   = $clog2(DIV_MAX);

  typedef logic [DIV_W-1:0] ratio_t;
  typedef logic [CNT_W-1:0] cnt_t;

  // Even, and inside 2..DIV_MAX
  function automatic logic ratio_legal(ratio_t v);
    return (v >= ratio_t'(2)) && (v <= ratio_t'(DIV_MAX)) && !v[0];
  endfunction

  // High phase length in advances for a legal ratio
  function automatic cnt_t high_time(ratio_t v);
    ratio_t half;
    half = v >> 1;
    if (v == ratio_t'(2) || v[1:0] == 2'b00) return cnt_t'(half);
    else return cnt_t'(half - ratio_t'(1));
  endfunction
endpackage

// File: rtl/clkdiv_tick_gen.sv
module clkdiv_tick_gen #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bypass_i,
  input  logic ref_i,
  output logic tick_o
);
  logic [SYNC_STAGES:0] sync_q;
  logic                 ref_rise;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-1:0], ref_i};
  end

  assign ref_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  assign tick_o   = bypass_i ? ref_rise : 1'b1;
endmodule

// File: rtl/clkdiv_channel.sv
module clkdiv_channel
  import clkdiv_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   tick_i,
  input  ratio_t ratio_i,
  input  logic   legal_i,
  output logic   raw_o
);
  cnt_t cnt_q, cnt_nx, last, high;
  logic armed_q, raw_q;

  assign last   = cnt_t'(ratio_i - ratio_t'(1));
  assign high   = high_time(ratio_i);
  assign cnt_nx = cnt_q + cnt_t'(1);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      raw_q   <= 1'b0;
    end else if (tick_i && legal_i) begin
      if (!armed_q || cnt_q == last) begin
        cnt_q   <= '0;
        raw_q   <= 1'b1;
        armed_q <= 1'b1;
      end else begin
        cnt_q <= cnt_nx;
        raw_q <= (cnt_nx < high);
      end
    end
  end

  assign raw_o = raw_q;
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    bypass_i,
  input  logic                    ref_i,
  input  logic [NUM_CH*DIV_W-1:0] ratio_i,
  input  logic [NUM_CH-1:0]       invert_i,
  output logic [NUM_CH-1:0]       clk_o,
  output logic [NUM_CH-1:0]       err_o
);
  logic              byp_q;
  logic              adv;
  logic [NUM_CH-1:0] inv_q, ok_q, div_raw;
  ratio_t            ratio_q [NUM_CH];

  always_ff @(posedge clk_i) begin
    if (!rst_ni) byp_q <= bypass_i;
  end

  clkdiv_tick_gen #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bypass_i (byp_q),
    .ref_i    (ref_i),
    .tick_o   (adv)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        ratio_q[g] <= ratio_i[g*DIV_W +: DIV_W];
        ok_q[g]    <= ratio_legal(ratio_i[g*DIV_W +: DIV_W]);
        inv_q[g]   <= invert_i[g];
      end
    end

    clkdiv_channel u_div (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (adv),
      .ratio_i (ratio_q[g]),
      .legal_i (ok_q[g]),
      .raw_o   (div_raw[g])
    );

    assign clk_o[g] = ok_q[g] & (div_raw[g] ^ inv_q[g]);
    assign err_o[g] = ~ok_q[g];
  end
endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic [NUM_CH-1:0] raw_i,
  input logic [NUM_CH-1:0] ok_i,
  input logic [NUM_CH-1:0] inv_i,
  input logic [NUM_CH-1:0] clk_o,
  input logic [NUM_CH-1:0] err_o
);
  logic started_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     started_q <= 1'b0;
    else if (tick_i) started_q <= 1'b1;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_err
    AST_ERR_FORCES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o[g] |-> !clk_o[g]); // R5
  end

  AST_IDLE_WITHOUT_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(raw_i)); // R6

  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> $stable({err_o, inv_i})); // R7

  AST_RESET_IDLE_LEVEL: assert property (@(posedge clk_i)
    !rst_ni |=> ((clk_o & ~inv_i) == '0)); // R8

  AST_ALIGNED_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !started_q) |=> (raw_i == ok_i)); // R8
endmodule

bind clkdiv_bank clkdiv_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tick_i (adv),
  .raw_i  (div_raw),
  .ok_i   (ok_q),
  .inv_i  (inv_q),
  .clk_o  (clk_o),
  .err_o  (err_o)
);

// File: tb/tb_clkdiv_bank.sv
module tb_clkdiv_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 4;
  localparam int DW         = 7;
  localparam int REF_P      = 4;

  logic                 clk = 1'b0;
  logic                 rst_ni = 1'b0;
  logic                 bypass = 1'b0;
  logic                 ref_in = 1'b0;
  logic [NUM_CH*DW-1:0] ratio = '0;
  logic [NUM_CH-1:0]    inv = '0;
  logic [NUM_CH-1:0]    clk_o, err_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkdiv_bank #(.NUM_CH(NUM_CH)) dut (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .bypass_i (bypass),
    .ref_i    (ref_in),
    .ratio_i  (ratio),
    .invert_i (inv),
    .clk_o    (clk_o),
    .err_o    (err_o)
  );

  function automatic bit legal(int v);
    return v >= 2 && v <= 64 && (v % 2) == 0;
  endfunction

  function automatic int hi(int v);
    return (v == 2 || v % 4 == 0) ? v / 2 : v / 2 - 1;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic hold_reset(input int rv[NUM_CH], input logic [NUM_CH-1:0] iv, input logic b);
    @(negedge clk);
    rst_ni = 1'b0;
    bypass = b;
    ref_in = 1'b0;
    inv    = iv;
    for (int c = 0; c < NUM_CH; c++) ratio[c*DW +: DW] = DW'(rv[c]);
    repeat (3) @(negedge clk);
    for (int c = 0; c < NUM_CH; c++) begin
      // R8 idle level in reset; R1/R5 error flag
      chk(clk_o[c] == (legal(rv[c]) & iv[c]), "R8 reset idle", int'(clk_o[c]), int'(legal(rv[c]) & iv[c]));
      chk(err_o[c] == !legal(rv[c]), legal(rv[c]) ? "R1 legal flag" : "R5 error flag", int'(err_o[c]), int'(!legal(rv[c])));
    end
    rst_ni = 1'b1;
  endtask

  // Direct mode: compare every cycle against the arithmetic waveform
  task automatic run_direct(input int rv[NUM_CH], input logic [NUM_CH-1:0] iv);
    hold_reset(rv, iv, 1'b0);
    // R7: scramble all settings at release
    ratio  = {NUM_CH{7'd3}};
    inv    = ~iv;
    bypass = 1'b1;
    for (int t = 0; t < 132; t++) begin
      @(negedge clk);
      for (int c = 0; c < NUM_CH; c++) begin
        logic e;
        string tag;
        if (!legal(rv[c])) begin
          e = 1'b0; tag = "R5 illegal low";
        end else begin
          e = (((t % rv[c]) < hi(rv[c])) ? 1'b1 : 1'b0) ^ iv[c];
          if (t == 0)                              tag = "R8 aligned first high";
          else if (iv[c])                          tag = "R4 inverted";
          else if (rv[c] == 2 || rv[c] % 4 == 0)   tag = "R2 half duty";
          else                                     tag = "R3 short high";
        end
        chk(clk_o[c] == e, tag, int'(clk_o[c]), int'(e));
      end
      if (t == 131) chk(err_o == ~{legal(rv[3]), legal(rv[2]), legal(rv[1]), legal(rv[0])},
                        "R7 flags frozen", int'(err_o), int'(~{legal(rv[3]), legal(rv[2]), legal(rv[1]), legal(rv[0])}) & 15);
    end
  endtask

  task automatic run_bypass(input int rv[NUM_CH]);
    int first [NUM_CH];
    int second[NUM_CH];
    int hcnt  [NUM_CH];
    logic [NUM_CH-1:0] prev;
    hold_reset(rv, '0, 1'b1);
    ratio = '0;
    bypass = 1'b0;
    prev = '0;
    for (int c = 0; c < NUM_CH; c++) begin first[c] = -1; second[c] = -1; hcnt[c] = 0; end
    for (int t = 0; t < 160; t++) begin
      @(negedge clk);
      if (t < 10) chk(clk_o == '0, "R6 no advance without ref", int'(clk_o), 0);
      for (int c = 0; c < NUM_CH; c++) begin
        if (clk_o[c] && !prev[c]) begin
          if (first[c] < 0) first[c] = t;
          else if (second[c] < 0) second[c] = t;
        end
        if (first[c] >= 0 && second[c] < 0 && clk_o[c]) hcnt[c]++;
      end
      prev = clk_o;
      ref_in = (t >= 10) && (((t - 10) % REF_P) < REF_P / 2);
    end
    for (int c = 0; c < NUM_CH; c++) begin
      chk(first[c] == first[0] && first[c] >= 0, "R8 bypass aligned start", first[c], first[0]);
      chk(second[c] - first[c] == rv[c] * REF_P, "R6 bypass period", second[c] - first[c], rv[c] * REF_P);
      chk(hcnt[c] == hi(rv[c]) * REF_P, "R6 bypass high time", hcnt[c], hi(rv[c]) * REF_P);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // Sweep every legal ratio, both polarities
    for (int g = 0; g < 8; g++) begin
      int rv[NUM_CH];
      for (int c = 0; c < NUM_CH; c++) rv[c] = 2 + 2 * (4 * g + c);
      run_direct(rv, 4'b0101);
      run_direct(rv, 4'b1010);
    end
    run_direct('{0, 1, 65, 127}, 4'b1111);   // R5 all illegal
    run_direct('{64, 7, 2, 100}, 4'b0110);   // R5 mixed with legal
    run_bypass('{2, 6, 12, 10});             // R6
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule